// File: doc/BRIEF.md
# Prioritised Interrupt Aggregator with Claim/Complete

This block collects four level-sensitive external interrupt lines for a single processor hart and presents them as one interrupt request. Software gives each source a 3-bit urgency level, turns each source on or off with an enable bit, and sets a 3-bit threshold. The request line is raised whenever some source is pending and enabled, and its level is strictly above the threshold. Level 0 therefore keeps a source silent.

To service an interrupt, software reads the claim register. The read returns the identifier of the winning source, or 0 when nothing qualifies. The same read removes that source's pending flag and marks the source as in service. While a source is in service, its line cannot make it pending again. Writing the identifier back to the same register ends service and re-arms the source. A line that is still high then becomes pending again on the next cycle, so no request is lost. Source identifiers run from 1 to 4, and identifier 0 means "no interrupt". By convention, identifier 1 is wired to the accelerator and identifier 2 to the serial port.

Access goes through a simple register port. A request is a one-cycle strobe with a write flag, an address and write data. Read data comes back one cycle later, qualified by a valid flag.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all levels, the enable bits, the threshold, the pending flags and the in-service state are zero, `irqOut` is low and `regRvalid` is low.
- R2: The level of source n (n = 1..4) sits at byte address 4*n, and only data bits [2:0] are kept. Address 0x000 is the slot of identifier 0: it always reads 0 and ignores writes.
- R3: The enable register is at 0x2000, where bit n enables source n. Bit 0 reads 0. A source whose enable bit is clear never raises `irqOut`.
- R4: The pending register at 0x1000 is read-only, with bit n for source n. `srcIrq[n-1]` high at a clock edge sets pending bit n at that edge, provided source n is neither pending nor in service. Once set, the bit stays set after the line drops.
- R5: `irqOut` is high exactly when some source is pending, enabled and has a level strictly greater than the threshold. It follows register changes in the cycle after the edge that made them.
- R6: A read of 0x200004 returns the identifier of the eligible source with the highest level. Ties go to the lowest identifier, and the read returns 0 when no source is eligible.
- R7: A claim read clears the winner's pending bit and marks the winner in service. While in service, the winner's pending bit stays clear even if its line is held high.
- R8: Writing an in-service identifier to 0x200004 ends its service. If the line is still high, the pending bit is set again one edge later.
- R9: A complete write is ignored if its identifier is 0, out of range, or not in service.
- R10: Read data and `regRvalid` appear one cycle after the read strobe. An unmapped or misaligned address reads 0, and a write never raises `regRvalid`.
- R11: The threshold register is at 0x200000 and keeps data bits [2:0]. A threshold of 7 holds `irqOut` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIrq | input | NUM_SRC | Interrupt lines; bit i is source identifier i+1 |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, valid with regRvalid |
| regRvalid | output | 1 | Read data valid, one cycle after the read strobe |
| irqOut | output | 1 | External interrupt request to the hart |

## Verification
The bench sweeps every combination of threshold, enable mask and several level patterns, one of which has all levels equal, while every line is held high. In each case it checks the request line, the claimed identifier and the pending flags against an arithmetic model.

Each corner case targets a specific fault:
- A design that compared the level with the threshold using "greater or equal" would claim sources at the threshold.
- A design that broke ties toward the highest identifier would return the wrong winner in the equal-level pattern.
- A design that let a held line re-pend during service would show the claimed bit set again before completion.
- Bogus completes with identifiers 0, 5, 7 and a non-claimed identifier catch a design that releases service on any write.
- A one-cycle pulse checks that pending is latched rather than followed.
- A write to the pending register checks that the register is read-only.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Register offsets whose values software depends on
  localparam int unsigned OFS_PEND  = 32'h0000_1000;
  localparam int unsigned OFS_EN    = 32'h0000_2000;
  localparam int unsigned OFS_THR   = 32'h0020_0000;
  localparam int unsigned OFS_CLAIM = 32'h0020_0004;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PRIO,
    RD_PEND,
    RD_EN,
    RD_THR,
    RD_CLAIM
  } rd_sel_e;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic       prioWr;
    logic [7:0] slotIdx;
    logic       enWr;
    logic       thrWr;
    logic       complWr;
    logic       claimRd;
    logic       rdEn;
    rd_sel_e    rdSel;
  } reg_strobe_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int NUM_SRC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output reg_strobe_t       stb,
  output logic              regRvalid
);

  localparam logic [ADDR_W-1:0] PRIO_END = ADDR_W'(4 * (NUM_SRC + 1));
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_THR    = ADDR_W'(OFS_THR);
  localparam logic [ADDR_W-1:0] A_CLAIM  = ADDR_W'(OFS_CLAIM);

  logic rdReq, wrReq;
  rd_sel_e sel;

  assign rdReq = regValid && !regWrite;
  assign wrReq = regValid && regWrite;

  always_comb begin
    stb = '0;
    sel = RD_NONE;
    if (regAddr < PRIO_END && regAddr[1:0] == 2'b00) begin
      sel        = RD_PRIO;
      stb.prioWr = wrReq;
    end else if (regAddr == A_PEND) begin
      sel = RD_PEND;
    end else if (regAddr == A_EN) begin
      sel      = RD_EN;
      stb.enWr = wrReq;
    end else if (regAddr == A_THR) begin
      sel       = RD_THR;
      stb.thrWr = wrReq;
    end else if (regAddr == A_CLAIM) begin
      sel         = RD_CLAIM;
      stb.complWr = wrReq;
      stb.claimRd = rdReq;
    end
    stb.slotIdx = 8'(regAddr >> 2);
    stb.rdEn    = rdReq;
    stb.rdSel   = sel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRvalid <= 1'b0;
    else       regRvalid <= rdReq;
  end

endmodule

// File: rtl/irq_agg_dpath.sv
module irq_agg_dpath
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  reg_strobe_t        stb,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               irqOut
);

  localparam int ID_W = $clog2(NUM_SRC + 1);

  logic [PRIO_W-1:0] prio [NUM_SRC:0];
  logic [NUM_SRC:0]  pend, pendNext;
  logic [NUM_SRC:0]  inSvc, inSvcNext;
  logic [NUM_SRC:0]  enBits;
  logic [NUM_SRC:0]  lineVec;
  logic [NUM_SRC:0]  claimHit, complHit;
  logic [PRIO_W-1:0] thr;
  logic [PRIO_W-1:0] bestPrio;
  logic [ID_W-1:0]   bestId;
  logic [DATA_W-1:0] rdMux;

  assign lineVec = {srcIrq, 1'b0};

  // Arbitration: strictly above the running best, so ties keep the lower ID
  always_comb begin
    bestPrio = thr;
    bestId   = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (pend[i] && enBits[i] && prio[i] > bestPrio) begin
        bestPrio = prio[i];
        bestId   = ID_W'(i);
      end
    end
  end

  assign irqOut = (bestId != '0);

  // Per-source gateway: claim, complete and line capture
  assign claimHit[0]  = 1'b0;
  assign complHit[0]  = 1'b0;
  assign pendNext[0]  = 1'b0;
  assign inSvcNext[0] = 1'b0;

  generate
    for (genvar g = 1; g <= NUM_SRC; g++) begin : gGate
      assign claimHit[g]  = stb.claimRd && (bestId == ID_W'(g));
      assign complHit[g]  = stb.complWr && (regWdata == DATA_W'(g)) && inSvc[g];
      assign pendNext[g]  = claimHit[g] ? 1'b0
                          : (pend[g] || (lineVec[g] && !inSvc[g]));
      assign inSvcNext[g] = claimHit[g] ? 1'b1
                          : (inSvc[g] && !complHit[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend   <= '0;
      inSvc  <= '0;
      enBits <= '0;
      thr    <= '0;
      for (int i = 0; i <= NUM_SRC; i++) prio[i] <= '0;
    end else begin
      pend  <= pendNext;
      inSvc <= inSvcNext;
      if (stb.enWr)  enBits <= {regWdata[NUM_SRC:1], 1'b0};
      if (stb.thrWr) thr    <= regWdata[PRIO_W-1:0];
      for (int i = 1; i <= NUM_SRC; i++) begin
        if (stb.prioWr && stb.slotIdx == 8'(i)) prio[i] <= regWdata[PRIO_W-1:0];
      end
    end
  end

  always_comb begin
    rdMux = '0;
    unique case (stb.rdSel)
      RD_PRIO: begin
        for (int i = 1; i <= NUM_SRC; i++) begin
          if (stb.slotIdx == 8'(i)) rdMux = DATA_W'(prio[i]);
        end
      end
      RD_PEND:  rdMux = DATA_W'(pend);
      RD_EN:    rdMux = DATA_W'(enBits);
      RD_THR:   rdMux = DATA_W'(thr);
      RD_CLAIM: rdMux = DATA_W'(bestId);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         regRdata <= '0;
    else if (stb.rdEn) regRdata <= rdMux;
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               regRvalid,
  output logic               irqOut
);

  reg_strobe_t stb;

  irq_agg_ctrl #(
    .ADDR_W (ADDR_W),
    .NUM_SRC(NUM_SRC)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .stb      (stb),
    .regRvalid(regRvalid)
  );

  irq_agg_dpath #(
    .NUM_SRC(NUM_SRC),
    .PRIO_W (PRIO_W),
    .DATA_W (DATA_W)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .srcIrq  (srcIrq),
    .stb     (stb),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIrq,
  input logic               regValid,
  input logic               regWrite,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWdata,
  input logic [DATA_W-1:0]  regRdata,
  input logic               regRvalid,
  input logic               irqOut
);

  localparam logic [ADDR_W-1:0] C_EN    = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] C_THR   = ADDR_W'(OFS_THR);
  localparam logic [ADDR_W-1:0] C_CLAIM = ADDR_W'(OFS_CLAIM);
  localparam logic [ADDR_W-1:0] C_HOLE  = ADDR_W'(32'h3000);

  logic rdReq, wrReq;
  assign rdReq = regValid && !regWrite;
  assign wrReq = regValid && regWrite;

  // R10: read data valid one cycle after a read request
  a_r10_rvalid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> regRvalid);

  // R10: no valid without a read request
  a_r10_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !regRvalid);

  // R10: a hole in the map reads zero
  a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && regAddr == C_HOLE) |=> (regRdata == '0));

  // R6: claim with no request pending returns 0
  a_r6_idle_claim_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && regAddr == C_CLAIM && !irqOut) |=> (regRdata == '0));

  // R6: claim while requesting returns a real source ID
  a_r6_claim_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && regAddr == C_CLAIM && irqOut) |=>
      (regRdata != '0 && regRdata <= DATA_W'(NUM_SRC)));

  // R11: maximum threshold silences the request
  a_r11_max_thr_silences: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && regAddr == C_THR && regWdata[PRIO_W-1:0] == '1) |=> !irqOut);

  // R3: clearing every enable silences the request
  a_r3_all_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && regAddr == C_EN && regWdata[NUM_SRC:1] == '0) |=> !irqOut);

endmodule

bind irq_aggregator irq_agg_checker #(
  .NUM_SRC(NUM_SRC),
  .PRIO_W (PRIO_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) uChk (.*);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;

  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  srcIrq;
  logic        regValid, regWrite;
  logic [21:0] regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        regRvalid;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  irq_aggregator dut (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .regRvalid(regRvalid),
    .irqOut(irqOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks begin and end just after a falling edge
  task automatic doWrite(input int addr, input int data);
    regValid = 1'b1; regWrite = 1'b1;
    regAddr = 22'(addr); regWdata = data;
    @(posedge clk); @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic doRead(input int addr, output int data);
    regValid = 1'b1; regWrite = 1'b0;
    regAddr = 22'(addr); regWdata = 0;
    @(posedge clk); @(negedge clk);
    regValid = 1'b0;
    chk("R10 rvalid", int'(regRvalid), 1);
    data = int'(regRdata);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  function automatic int model(input int p[5], input int en, input int thr);
    int best = thr;
    int id = 0;
    for (int i = 1; i <= NS; i++) begin
      if (en[i-1] && p[i] > best) begin best = p[i]; id = i; end
    end
    return id;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    int pr[5];
    rstN = 1'b0; srcIrq = '0; regValid = 0; regWrite = 0; regAddr = '0; regWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 irqOut", int'(irqOut), 0);
    chk("R1 rvalid", int'(regRvalid), 0);
    for (int i = 1; i <= NS; i++) begin doRead(4*i, d); chk("R1 prio", d, 0); end
    doRead('h1000, d); chk("R1 pending", d, 0);
    doRead('h2000, d); chk("R1 enable", d, 0);
    doRead('h200000, d); chk("R1 threshold", d, 0);
    doRead('h200004, d); chk("R1 claim empty", d, 0);

    // R2: level registers keep 3 bits; slot 0 fixed at 0
    for (int i = 0; i <= NS; i++) doWrite(4*i, 32'hFFFF_FFF8 | (i + 2));
    for (int i = 0; i <= NS; i++) begin
      doRead(4*i, d);
      chk("R2 prio readback", d, (i == 0) ? 0 : ((i + 2) & 7));
    end

    // R10: holes, misalignment, writes give no valid
    doRead('h3000, d); chk("R10 hole", d, 0);
    doRead('h2, d);    chk("R10 misaligned", d, 0);
    doWrite('h3000, 5);
    chk("R10 no rvalid on write", int'(regRvalid), 0);

    // R11: threshold keeps 3 bits
    doWrite('h200000, 32'hFFFF_FFF9);
    doRead('h200000, d); chk("R11 threshold bits", d, 1);
    doWrite('h200000, 0);

    // R4: single-cycle pulse on ID3 is latched; register is read-only
    srcIrq = 4'b0100;
    @(posedge clk); @(negedge clk);
    srcIrq = 4'b0000;
    idle(2);
    doRead('h1000, d); chk("R4 pulse latched", d, 8);
    doWrite('h1000, 0);
    doRead('h1000, d); chk("R4 read-only", d, 8);
    // R3: disabled pending source stays silent
    chk("R3 disabled silent", int'(irqOut), 0);
    doWrite('h2000, 32'hFFFF_FFFF);
    doRead('h2000, d); chk("R3 enable bit0 zero", d, 'h1E);
    chk("R5 irq raised", int'(irqOut), 1);
    doWrite('h200000, 7);
    chk("R11 max threshold", int'(irqOut), 0);
    doWrite('h200000, 5);
    chk("R5 level equal to threshold", int'(irqOut), 0);
    doWrite('h200000, 4);
    chk("R5 level above threshold", int'(irqOut), 1);
    doWrite('h200000, 0);

    // R6/R7: claim ID3
    doRead('h200004, d); chk("R6 claim id3", d, 3);
    chk("R7 irq drops after claim", int'(irqOut), 0);
    doRead('h1000, d); chk("R7 pending cleared", d, 0);

    // R9: bogus completes, then hold the line; must stay in service
    doWrite('h200004, 0);
    doWrite('h200004, 5);
    doWrite('h200004, 7);
    doWrite('h200004, 2);
    srcIrq = 4'b0100;
    idle(3);
    doRead('h1000, d); chk("R9 bogus complete ignored / R7 no re-pend", d, 0);
    // R8: proper complete re-arms while line held
    doWrite('h200004, 3);
    idle(1);
    doRead('h1000, d); chk("R8 re-pend after complete", d, 8);
    doRead('h200004, d); chk("R6 reclaim id3", d, 3);
    doWrite('h200004, 3);

    // Sweep: all lines high, every threshold x enable mask x level pattern
    srcIrq = 4'hF;
    idle(2);
    for (int pat = 0; pat < 5; pat++) begin
      for (int i = 1; i <= NS; i++) begin
        pr[i] = (pat < 4) ? ((pat*5 + i*3 + pat*i) % 8) : 5;
        doWrite(4*i, pr[i]);
      end
      pr[0] = 0;
      for (int en = 0; en < 16; en++) begin
        doWrite('h2000, en << 1);
        for (int thr = 0; thr < 8; thr++) begin
          int exp;
          doWrite('h200000, thr);
          exp = model(pr, en, thr);
          chk("R5 irq sweep", int'(irqOut), (exp != 0) ? 1 : 0);
          doRead('h200004, d); chk("R6 claim sweep", d, exp);
          doRead('h1000, d);
          chk("R7 pending after claim", d, (exp != 0) ? ('h1E & ~(1 << exp)) : 'h1E);
          if (exp != 0) begin
            doWrite('h200004, exp);
            idle(1);
            doRead('h1000, d); chk("R8 restored", d, 'h1E);
          end
        end
      end
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule